// File: doc/BRIEF.md
# Oversampled I2C Control and Status Register Target

This block is a two-wire serial target that a host uses to configure a serial link front end. It answers only at 7-bit bus address 0x42. Behind it sit eight byte-wide registers: seven hold control values and drive the block's control outputs (power and isolation, transmit and receive options, source select, clock synthesizer tuning and reset, recovery loop gain and reset, debug probe select). The eighth reports live lock flags together with latched error flags.

Both bus lines are sampled by the system clock through two-flop synchronizers. A START is a falling SDA while SCL is high, and a STOP is a rising SDA while SCL is high. The target receives a bit on each SCL rise and moves SDA only after an SCL fall. It pulls SDA low through an output enable and never drives it high.

A write has three bytes: the address with the write bit, the register index, and the data. A read first sends the address with the write bit and then the index. The host then issues a repeated START, the address with the read bit, and clocks out one byte MSB first, which it ends with NACK and STOP.

The state machine has these states:
- ST_IDLE: waits for a START.
- ST_ADDR: receives the address byte.
- ST_ADDR_ACK: acknowledges the address.
- ST_REG: receives the index byte.
- ST_REG_ACK: acknowledges the index.
- ST_DATA: receives the write data.
- ST_DATA_ACK: acknowledges the data.
- ST_TX: shifts out the read byte.
- ST_TX_ACK: receives the host's acknowledge bit.
- ST_WAIT: ignores the bus until the next START or STOP.

Its transitions are:
- A START in any state leads to ST_ADDR, and a STOP in any state leads to ST_IDLE.
- After the eighth address bit, a matching address leads to ST_ADDR_ACK and any other address leads to ST_WAIT.
- ST_ADDR_ACK leads to ST_TX when the read bit was set and to ST_REG otherwise.
- After the eighth index bit, an index below 8 leads to ST_REG_ACK and any other index leads to ST_WAIT.
- ST_REG_ACK leads to ST_DATA, and ST_DATA leads to ST_DATA_ACK.
- ST_DATA_ACK, ST_TX then ST_TX_ACK all end in ST_WAIT.

Top module: `phy_cfg_i2c`

## Requirements
- R1: After reset the outputs read as follows: ctl_phy = 0x02 (bit 1 isolation = 1, bit 0 enable = 0), ctl_pll = 0x68 (trim [3:0] = 8, pump current [5:4] = 2, reset bit 6 = 1), ctl_cdr = 0x14 (gain [2:0] = 4, reset bit 4 = 1). All other control registers are 0x00, and sda_oe is 0.
- R2: The target acknowledges (pulls SDA low in the ninth bit) only for address byte 0x84 (write) or 0x85 (read). Any other address gets no acknowledge, and the bytes that follow it up to the next START get no acknowledge and change no register.
- R3: A write with index 0..7 acknowledges each of its three bytes and loads the data into the register at that index. Index 0 drives ctl_phy, 1 ctl_tx, 2 ctl_rx, 3 ctl_sel, 4 ctl_pll, 5 ctl_cdr and 7 ctl_dbg.
- R4: A read using a repeated START returns the addressed register MSB first, on the SCL high phases after the read address is acknowledged.
- R5: An index byte of 8 or more is not acknowledged, and the data byte after it is ignored.
- R6: Status (index 6) bit 0 is the live pll_lock_in and bit 1 is the live cdr_lock_in. Bits 3, 4, 5 and 7 read 0.
- R7: Status bit 2 (FIFO error) and bit 6 (PRBS error) are set by a one-cycle high on fifo_err_in or prbs_err_in. They hold until a status read reports them, and they read 0 on the next read.
- R8: A write to index 6 is acknowledged but changes no register and no control output.
- R9: In the debug register only bits [2:0] are kept, and of those only the lowest set bit. Writing 0x06 gives 0x02, and writing 0xF0 gives 0x00.
- R10: A START in the middle of a byte abandons that transfer and begins a new address phase. SDA changes only while SCL is low, and a STOP releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low |
| pll_lock_in | input | 1 | Synthesizer lock flag |
| cdr_lock_in | input | 1 | Clock recovery lock flag |
| fifo_err_in | input | 1 | FIFO error event |
| prbs_err_in | input | 1 | PRBS mismatch event |
| ctl_phy | output | 8 | Enable and isolation register |
| ctl_tx | output | 8 | Transmit options register |
| ctl_rx | output | 8 | Receive options register |
| ctl_sel | output | 8 | Data source select register |
| ctl_pll | output | 8 | Synthesizer tuning and reset register |
| ctl_cdr | output | 8 | Recovery gain and reset register |
| ctl_dbg | output | 8 | Debug probe select register |

## Verification
The assertions assume a well-behaved single host. SDA moves only while SCL is low, except for deliberate START and STOP conditions. SCL and SDA never change in the same system cycle. Each bus phase lasts many system clocks, so the synchronizer delay is short compared with any phase. The bench drives every line at the falling system edge, holds each quarter bit for 20 clocks, and changes SDA only while SCL is low or for START and STOP. It also ends every read with NACK before STOP, so the target has released SDA before the bus returns to idle.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;

    localparam int unsigned NUM_REGS   = 8;
    localparam int unsigned IDX_W      = $clog2(NUM_REGS);
    localparam int unsigned STATUS_IDX = 6;
    localparam int unsigned DEBUG_IDX  = 7;
    localparam int unsigned DBG_SRCS   = 3;

    localparam logic [7:0] RST_PHY = 8'h02;
    localparam logic [7:0] RST_PLL = 8'h68;
    localparam logic [7:0] RST_CDR = 8'h14;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_WAIT
    } tgt_state_t;

    function automatic logic [7:0] reset_value(int unsigned idx);
        case (idx)
            0:       return RST_PHY;
            4:       return RST_PLL;
            5:       return RST_CDR;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[STAGES-2:0], sda_in};
            scl_d  <= scl_ff[STAGES-1];
            sda_d  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import phy_cfg_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h42
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rd_data,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             rd_load,
    output logic [IDX_W-1:0] rd_idx,
    output logic             sda_oe
);
    tgt_state_t       state_q, state_d;
    logic [3:0]       cnt_q;
    logic [7:0]       shreg_q, txsh_q;
    logic [IDX_W-1:0] idx_q;
    logic             byte_done, addr_match, idx_ok, receiving;

    assign byte_done  = (cnt_q == 4'd8);
    assign addr_match = (shreg_q[7:1] == TARGET_ADDR);
    assign idx_ok     = (shreg_q[7:IDX_W] == '0);
    assign receiving  = (state_q == ST_ADDR) || (state_q == ST_REG) || (state_q == ST_DATA);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_WAIT: state_d = state_q;
                ST_ADDR:     if (scl_fall && byte_done) state_d = addr_match ? ST_ADDR_ACK : ST_WAIT;
                ST_ADDR_ACK: if (scl_fall) state_d = shreg_q[0] ? ST_TX : ST_REG;
                ST_REG:      if (scl_fall && byte_done) state_d = idx_ok ? ST_REG_ACK : ST_WAIT;
                ST_REG_ACK:  if (scl_fall) state_d = ST_DATA;
                ST_DATA:     if (scl_fall && byte_done) state_d = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) state_d = ST_WAIT;
                ST_TX:       if (scl_fall && byte_done) state_d = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) state_d = ST_WAIT;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // bit counter, shifters and register pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            txsh_q  <= '0;
            idx_q   <= '0;
        end else if (start_det) begin
            cnt_q <= '0;
        end else begin
            if (scl_rise && (receiving || state_q == ST_TX)) begin
                cnt_q <= cnt_q + 4'd1;
                if (receiving) shreg_q <= {shreg_q[6:0], sda_s};
            end
            if (scl_fall) begin
                if (state_q == ST_ADDR_ACK || state_q == ST_REG_ACK) cnt_q <= '0;
                if (state_q == ST_ADDR_ACK && shreg_q[0]) txsh_q <= rd_data;
                if (state_q == ST_TX && !byte_done) txsh_q <= {txsh_q[6:0], 1'b0};
                if (state_q == ST_REG && byte_done && idx_ok) idx_q <= shreg_q[IDX_W-1:0];
            end
        end
    end

    // outputs
    always_comb begin
        wr_en   = (state_q == ST_DATA) && scl_fall && byte_done && !start_det && !stop_det;
        wr_idx  = idx_q;
        wr_data = shreg_q;
        rd_load = (state_q == ST_ADDR_ACK) && scl_fall && shreg_q[0] && !start_det && !stop_det;
        rd_idx  = idx_q;
        sda_oe  = (state_q == ST_ADDR_ACK) || (state_q == ST_REG_ACK) ||
                  (state_q == ST_DATA_ACK) || (state_q == ST_TX && !txsh_q[7]);
    end

    // R2: a foreign address never earns an acknowledge
    p_foreign_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR && scl_fall && byte_done && !addr_match && !start_det && !stop_det)
            |=> !sda_oe);

    // R10: the target moves SDA only while SCL is low
    p_sda_rise_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);
    p_sda_fall_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> (!scl_s || stop_det || start_det || $past(stop_det) || $past(start_det)));

    // R10: START restarts the address phase, STOP idles and releases
    p_start_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state_q == ST_ADDR && cnt_q == 4'd0));
    p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == ST_IDLE && !sda_oe));

endmodule

// File: rtl/phy_cfg_regs.sv
module phy_cfg_regs
    import phy_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic             rd_load,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    input  logic             pll_lock_in,
    input  logic             cdr_lock_in,
    input  logic             fifo_err_in,
    input  logic             prbs_err_in,
    output logic [7:0]       ctl_phy,
    output logic [7:0]       ctl_tx,
    output logic [7:0]       ctl_rx,
    output logic [7:0]       ctl_sel,
    output logic [7:0]       ctl_pll,
    output logic [7:0]       ctl_cdr,
    output logic [7:0]       ctl_dbg
);
    logic [7:0]            ctrl_q [NUM_REGS];
    logic [NUM_REGS*8-1:0] ctrl_flat;
    logic                  fifo_q, prbs_q, status_clr;
    logic [7:0]            status_byte;
    logic [DBG_SRCS-1:0]   dbg_req, dbg_pick;

    assign dbg_req  = wr_data[DBG_SRCS-1:0];
    assign dbg_pick = dbg_req & (~dbg_req + 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) ctrl_q[i] <= reset_value(i);
        end else if (wr_en) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_idx == IDX_W'(i) && i != STATUS_IDX) begin
                    if (i == DEBUG_IDX) ctrl_q[i] <= {{(8-DBG_SRCS){1'b0}}, dbg_pick};
                    else                ctrl_q[i] <= wr_data;
                end
            end
        end
    end

    assign status_clr = rd_load && (rd_idx == IDX_W'(STATUS_IDX));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_q <= 1'b0;
            prbs_q <= 1'b0;
        end else begin
            fifo_q <= fifo_err_in | (fifo_q & ~status_clr);
            prbs_q <= prbs_err_in | (prbs_q & ~status_clr);
        end
    end

    assign status_byte = {1'b0, prbs_q, 3'b000, fifo_q, cdr_lock_in, pll_lock_in};
    assign rd_data     = (rd_idx == IDX_W'(STATUS_IDX)) ? status_byte : ctrl_q[rd_idx];

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
            assign ctrl_flat[g*8 +: 8] = ctrl_q[g];
        end
    endgenerate

    assign ctl_phy = ctrl_q[0];
    assign ctl_tx  = ctrl_q[1];
    assign ctl_rx  = ctrl_q[2];
    assign ctl_sel = ctrl_q[3];
    assign ctl_pll = ctrl_q[4];
    assign ctl_cdr = ctrl_q[5];
    assign ctl_dbg = ctrl_q[DEBUG_IDX];

    // R3: an accepted write lands in the addressed register
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != IDX_W'(STATUS_IDX) && wr_idx != IDX_W'(DEBUG_IDX))
            |=> ctrl_q[$past(wr_idx)] == $past(wr_data));

    // R7: sticky error bits hold until a status read clears them
    p_sticky_fifo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_q && !status_clr) |=> fifo_q);
    p_sticky_prbs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (prbs_q && !status_clr) |=> prbs_q);

    // R8: writing the status index leaves every register untouched
    p_status_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(STATUS_IDX)) |=> $stable(ctrl_flat));

    // R9: at most one debug source is ever selected
    p_dbg_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctrl_q[DEBUG_IDX]));

endmodule

// File: rtl/phy_cfg_i2c.sv
module phy_cfg_i2c
    import phy_cfg_pkg::*;
#(
    parameter logic [6:0]  TARGET_ADDR = 7'h42,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    input  logic       pll_lock_in,
    input  logic       cdr_lock_in,
    input  logic       fifo_err_in,
    input  logic       prbs_err_in,
    output logic [7:0] ctl_phy,
    output logic [7:0] ctl_tx,
    output logic [7:0] ctl_rx,
    output logic [7:0] ctl_sel,
    output logic [7:0] ctl_pll,
    output logic [7:0] ctl_cdr,
    output logic [7:0] ctl_dbg
);
    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en, rd_load;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [7:0]       wr_data, rd_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_target_fsm #(.TARGET_ADDR(TARGET_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_load   (rd_load),
        .rd_idx    (rd_idx),
        .sda_oe    (sda_oe)
    );

    phy_cfg_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .rd_load     (rd_load),
        .rd_idx      (rd_idx),
        .rd_data     (rd_data),
        .pll_lock_in (pll_lock_in),
        .cdr_lock_in (cdr_lock_in),
        .fifo_err_in (fifo_err_in),
        .prbs_err_in (prbs_err_in),
        .ctl_phy     (ctl_phy),
        .ctl_tx      (ctl_tx),
        .ctl_rx      (ctl_rx),
        .ctl_sel     (ctl_sel),
        .ctl_pll     (ctl_pll),
        .ctl_cdr     (ctl_cdr),
        .ctl_dbg     (ctl_dbg)
    );

endmodule

// File: tb/test_phy_cfg_i2c.sv
module test_phy_cfg_i2c;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 20;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_drv = 1'b1;
    logic       sda_oe;
    logic       sda_line;
    logic       pll_lock = 1'b0, cdr_lock = 1'b0, fifo_err = 1'b0, prbs_err = 1'b0;
    logic [7:0] ctl_phy, ctl_tx, ctl_rx, ctl_sel, ctl_pll, ctl_cdr, ctl_dbg;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    assign sda_line = sda_drv & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_cfg_i2c i_phy_cfg_i2c (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_in      (scl),
        .sda_in      (sda_line),
        .sda_oe      (sda_oe),
        .pll_lock_in (pll_lock),
        .cdr_lock_in (cdr_lock),
        .fifo_err_in (fifo_err),
        .prbs_err_in (prbs_err),
        .ctl_phy     (ctl_phy),
        .ctl_tx      (ctl_tx),
        .ctl_rx      (ctl_rx),
        .ctl_sel     (ctl_sel),
        .ctl_pll     (ctl_pll),
        .ctl_cdr     (ctl_cdr),
        .ctl_dbg     (ctl_dbg)
    );

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wait_q();
        scl = 1'b1;     wait_q();
        sda_drv = 1'b0; wait_q();
        scl = 1'b0;     wait_q();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wait_q();
        scl = 1'b1;     wait_q();
        sda_drv = 1'b1; wait_q();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_drv = b[i]; wait_q();
            scl = 1'b1;     wait_q();
            scl = 1'b0;     wait_q();
        end
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack_n);
        send_bits(b, 8);
        sda_drv = 1'b1; wait_q();
        scl = 1'b1;     wait_q();
        ack_n = sda_line;
        scl = 1'b0;     wait_q();
    endtask

    task automatic read_byte(output logic [7:0] b, input logic nack);
        sda_drv = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_q();
            scl = 1'b1; wait_q();
            b[i] = sda_line;
            scl = 1'b0; wait_q();
        end
        sda_drv = nack; wait_q();
        scl = 1'b1;     wait_q();
        scl = 1'b0;     wait_q();
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [7:0] data, output logic [2:0] acks_n);
        bus_start();
        write_byte(8'h84, acks_n[2]);
        write_byte(idx,   acks_n[1]);
        write_byte(data,  acks_n[0]);
        bus_stop();
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [7:0] data, output logic [2:0] acks_n);
        bus_start();
        write_byte(8'h84, acks_n[2]);
        write_byte(idx,   acks_n[1]);
        bus_start();
        write_byte(8'h85, acks_n[0]);
        read_byte(data, 1'b1);
        bus_stop();
    endtask

    // R1: reset values on the control outputs and over the bus
    task automatic t_reset();
        logic [7:0] d; logic [2:0] a;
        check(ctl_phy == 8'h02, "R1 ctl_phy", ctl_phy, 8'h02);
        check(ctl_pll == 8'h68, "R1 ctl_pll", ctl_pll, 8'h68);
        check(ctl_cdr == 8'h14, "R1 ctl_cdr", ctl_cdr, 8'h14);
        check({ctl_tx | ctl_rx | ctl_sel | ctl_dbg} == 8'h00, "R1 zero regs",
              ctl_tx | ctl_rx | ctl_sel | ctl_dbg, 8'h00);
        check(sda_oe == 1'b0, "R1 sda released", {7'd0, sda_oe}, 8'h00);
        reg_read(8'h04, d, a);
        check(a == 3'b000, "R4 read acks", {5'd0, a}, 8'h00);
        check(d == 8'h68, "R4 read pll reset value", d, 8'h68);
    endtask

    // R3, R4: write then read back
    task automatic t_write_read();
        logic [7:0] d; logic [2:0] a;
        reg_write(8'h01, 8'hA5, a);
        check(a == 3'b000, "R3 write acks", {5'd0, a}, 8'h00);
        check(ctl_tx == 8'hA5, "R3 ctl_tx", ctl_tx, 8'hA5);
        reg_write(8'h03, 8'h3C, a);
        check(ctl_sel == 8'h3C, "R3 ctl_sel", ctl_sel, 8'h3C);
        reg_read(8'h01, d, a);
        check(d == 8'hA5, "R4 read ctl_tx", d, 8'hA5);
        reg_read(8'h03, d, a);
        check(d == 8'h3C, "R4 read ctl_sel", d, 8'h3C);
    endtask

    // R2: foreign address
    task automatic t_foreign();
        logic a0, a1, a2;
        bus_start();
        write_byte(8'h86, a0);
        write_byte(8'h01, a1);
        write_byte(8'h77, a2);
        bus_stop();
        check(a0 == 1'b1, "R2 foreign addr nack", {7'd0, a0}, 8'h01);
        check(a1 & a2, "R2 following bytes nack", {6'd0, a1, a2}, 8'h03);
        check(ctl_tx == 8'hA5, "R2 ctl_tx untouched", ctl_tx, 8'hA5);
    endtask

    // R5: out-of-range index
    task automatic t_bad_index();
        logic [2:0] a;
        reg_write(8'h09, 8'h55, a);
        check(a == 3'b011, "R5 index nack", {5'd0, a}, 8'h03);
        check(ctl_tx == 8'hA5, "R5 ctl_tx untouched", ctl_tx, 8'hA5);
    endtask

    // R6: live lock bits
    task automatic t_status_live();
        logic [7:0] d; logic [2:0] a;
        pll_lock = 1'b1; cdr_lock = 1'b0;
        reg_read(8'h06, d, a);
        check(d == 8'h01, "R6 pll only", d, 8'h01);
        cdr_lock = 1'b1;
        reg_read(8'h06, d, a);
        check(d == 8'h03, "R6 both locks", d, 8'h03);
        pll_lock = 1'b0; cdr_lock = 1'b0;
        reg_read(8'h06, d, a);
        check(d == 8'h00, "R6 no locks", d, 8'h00);
    endtask

    // R7: sticky error bits clear on read
    task automatic t_sticky();
        logic [7:0] d; logic [2:0] a;
        @(negedge clk) fifo_err = 1'b1;
        @(negedge clk) fifo_err = 1'b0;
        reg_read(8'h06, d, a);
        check(d == 8'h04, "R7 fifo sticky seen", d, 8'h04);
        reg_read(8'h06, d, a);
        check(d == 8'h00, "R7 fifo cleared", d, 8'h00);
        @(negedge clk) prbs_err = 1'b1;
        @(negedge clk) prbs_err = 1'b0;
        wait_q();
        reg_read(8'h06, d, a);
        check(d == 8'h40, "R7 prbs sticky seen", d, 8'h40);
        reg_read(8'h06, d, a);
        check(d == 8'h00, "R7 prbs cleared", d, 8'h00);
    endtask

    // R8: status register is read-only
    task automatic t_status_ro();
        logic [7:0] d; logic [2:0] a;
        reg_write(8'h06, 8'hFF, a);
        check(a == 3'b000, "R8 status write acked", {5'd0, a}, 8'h00);
        reg_read(8'h06, d, a);
        check(d == 8'h00, "R8 status unchanged", d, 8'h00);
        check(ctl_phy == 8'h02 && ctl_tx == 8'hA5 && ctl_rx == 8'h00 && ctl_sel == 8'h3C &&
              ctl_pll == 8'h68 && ctl_cdr == 8'h14 && ctl_dbg == 8'h00,
              "R8 controls unchanged", ctl_tx, 8'hA5);
    endtask

    // R9: debug select keeps the lowest set source bit
    task automatic t_debug();
        logic [7:0] d; logic [2:0] a;
        reg_write(8'h07, 8'h06, a);
        check(ctl_dbg == 8'h02, "R9 0x06", ctl_dbg, 8'h02);
        reg_write(8'h07, 8'h05, a);
        check(ctl_dbg == 8'h01, "R9 0x05", ctl_dbg, 8'h01);
        reg_write(8'h07, 8'h04, a);
        reg_read(8'h07, d, a);
        check(d == 8'h04, "R9 0x04 readback", d, 8'h04);
        reg_write(8'h07, 8'hF0, a);
        check(ctl_dbg == 8'h00, "R9 0xF0", ctl_dbg, 8'h00);
    endtask

    // R10: START mid-byte abandons the transfer
    task automatic t_restart();
        logic [2:0] a; logic x;
        bus_start();
        write_byte(8'h84, x);
        send_bits(8'h02, 3);
        bus_start();
        write_byte(8'h84, a[2]);
        write_byte(8'h02, a[1]);
        write_byte(8'h11, a[0]);
        bus_stop();
        check(a == 3'b000, "R10 restart acks", {5'd0, a}, 8'h00);
        check(ctl_rx == 8'h11, "R10 ctl_rx after restart", ctl_rx, 8'h11);
        wait_q();
        check(sda_oe == 1'b0, "R10 released after stop", {7'd0, sda_oe}, 8'h00);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_read();
        t_foreign();
        t_bad_index();
        t_status_live();
        t_sticky();
        t_status_ro();
        t_debug();
        t_restart();
        finish_run();
    end

endmodule